// File: doc/BRIEF.md
# Extended-capability parallel port forward receiver

This block sits on the peripheral side of a bidirectional parallel link and takes bytes that the host sends toward the peripheral. The host puts a byte on the eight data lines and marks it as data or as a command with a separate class line. It then pulls its strobe low. The receiver answers by raising its acknowledge line. The byte is captured when the strobe returns high. The acknowledge drops again once the receiver can take the next byte.

Command bytes are not passed downstream. A command with its top bit clear holds a repeat count. A command with its top bit set selects a logical channel inside the peripheral. A pending repeat count makes the next data byte come out several times, so a pair of link bytes can stand for up to 128 output bytes. Output leaves on a valid/ready byte stream, next to a registered current-channel value.

The strobe is resynchronised into the local clock domain. The data and class lines are sampled only after the synchronised strobe has risen, which is while the acknowledge is still high and the host is therefore holding them.

Top module: `ecp_fwd_rx`

## Requirements
- R1: After reset, `periph_ack_o` is low, `out_vld_o` is low, `chan_o` is 0 and no repeat count is pending.
- R2: `periph_ack_o` rises once the synchronised `host_clk_i` has been seen low. The byte on `pd_i` is captured when the synchronised `host_clk_i` is next seen high. `periph_ack_o` then falls once the receiver has taken that byte.
- R3: `host_ack_i` high at capture marks the byte as data, which goes to the output stream. `host_ack_i` low marks the byte as a command, which never appears on the output stream, even if the byte value looks like data.
- R4: For a command byte with bit 7 = 0, bits 6:0 form a repeat count n. The next data byte is then emitted n+1 times, after which the count returns to 0. A data byte with no pending count is emitted once.
- R5: A later repeat-count command replaces a pending one. A channel command leaves a pending count unchanged.
- R6: For a command byte with bit 7 = 1, `chan_o` takes bits 6:0. It holds that value until the next channel command.
- R7: While `out_vld_o` is high and `out_rdy_i` is low, `out_vld_o` stays high and `out_data_o` stays stable.
- R8: A data byte that arrives while copies of an earlier byte are still waiting on the output stalls the link. `periph_ack_o` stays high until the stream has room.
- R9: A command byte is accepted even while an expansion is still draining. A new data byte may enter in the same cycle that the last copy of its predecessor leaves.
- R10: A count of 127 yields exactly 128 copies, which meets a compression ratio of 64:1 or better over two link bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_i | input | 8 | Byte presented by the host |
| host_ack_i | input | 1 | Byte class: 1 = data, 0 = command |
| host_clk_i | input | 1 | Host strobe, active low, asynchronous |
| periph_ack_o | output | 1 | Peripheral acknowledge / link busy |
| out_vld_o | output | 1 | Output byte valid |
| out_rdy_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Output byte |
| chan_o | output | 7 | Current channel address |

## Verification
Two things can coincide in one cycle. The first is a command byte being absorbed while a run is still draining. The second is a new data byte being loaded in the same cycle that the final copy of the previous run leaves. The first is provoked by holding ready low during a long run and then sending a channel command. That command must complete, and the channel must change while the old byte is still on the output. The second arises throughout a sweep of every repeat count under a throttled ready pattern. There, each output byte is compared in order against a stream computed in the bench from the counts sent, so any lost, duplicated or reordered copy at a run boundary is reported.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  localparam int PD_W  = 8;
  localparam int ARG_W = PD_W - 1;

  typedef enum logic [1:0] {
    LNK_IDLE = 2'd0,
    LNK_ACK  = 2'd1,
    LNK_CAPT = 2'd2
  } lnk_state_e;

  typedef struct packed {
    logic            is_cmd;
    logic [PD_W-1:0] val;
  } link_byte_t;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecp_link_fsm.sv
module ecp_link_fsm
  import ecp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hclk_sync_i,
  input  logic [PD_W-1:0] pd_i,
  input  logic            host_ack_i,
  input  logic            take_i,
  output logic            periph_ack_o,
  output logic            lb_vld_o,
  output link_byte_t      lb_o
);
  lnk_state_e state_q, state_d;
  link_byte_t cap_q, cap_d;
  logic       cap_en;

  always_comb begin
    state_d = state_q;
    cap_d   = cap_q;
    cap_en  = 1'b0;
    unique case (state_q)
      LNK_IDLE: if (!hclk_sync_i) state_d = LNK_ACK;
      LNK_ACK: begin
        if (hclk_sync_i) begin
          cap_en  = 1'b1;
          cap_d   = '{is_cmd: ~host_ack_i, val: pd_i};
          state_d = LNK_CAPT;
        end
      end
      LNK_CAPT: if (take_i) state_d = LNK_IDLE;
      default: state_d = LNK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LNK_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  assign periph_ack_o = (state_q != LNK_IDLE);
  assign lb_vld_o     = (state_q == LNK_CAPT);
  assign lb_o         = cap_q;
endmodule

// File: rtl/ecp_rle_expander.sv
module ecp_rle_expander
  import ecp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lb_vld_i,
  input  link_byte_t       lb_i,
  output logic             take_o,
  output logic             out_vld_o,
  input  logic             out_rdy_i,
  output logic [PD_W-1:0]  out_data_o,
  output logic [ARG_W-1:0] chan_o
);
  logic [ARG_W-1:0] run_q, run_d;
  logic [ARG_W-1:0] rep_q, rep_d;
  logic [ARG_W-1:0] chan_q, chan_d;
  logic [PD_W-1:0]  dat_q, dat_d;
  logic             vld_q, vld_d;
  logic             last_go, data_room, is_chan;

  assign last_go   = vld_q & out_rdy_i & (rep_q == '0);
  assign data_room = ~vld_q | last_go;
  assign take_o    = lb_vld_i & (lb_i.is_cmd | data_room);
  assign is_chan   = lb_i.val[PD_W-1];

  always_comb begin
    run_d  = run_q;
    rep_d  = rep_q;
    chan_d = chan_q;
    dat_d  = dat_q;
    vld_d  = vld_q;
    if (vld_q && out_rdy_i) begin
      if (rep_q == '0) vld_d = 1'b0;
      else             rep_d = rep_q - 1'b1;
    end
    if (take_o) begin
      if (lb_i.is_cmd) begin
        if (is_chan) chan_d = lb_i.val[ARG_W-1:0];
        else         run_d  = lb_i.val[ARG_W-1:0];
      end else begin
        dat_d = lb_i.val;
        vld_d = 1'b1;
        rep_d = run_q;
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      rep_q  <= '0;
      chan_q <= '0;
      dat_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      rep_q  <= rep_d;
      chan_q <= chan_d;
      dat_q  <= dat_d;
      vld_q  <= vld_d;
    end
  end

  assign out_vld_o  = vld_q;
  assign out_data_o = dat_q;
  assign chan_o     = chan_q;
endmodule

// File: rtl/ecp_fwd_rx.sv
module ecp_fwd_rx
  import ecp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PD_W-1:0]  pd_i,
  input  logic             host_ack_i,
  input  logic             host_clk_i,
  output logic             periph_ack_o,
  output logic             out_vld_o,
  input  logic             out_rdy_i,
  output logic [PD_W-1:0]  out_data_o,
  output logic [ARG_W-1:0] chan_o
);
  logic       rst_sync_n;
  logic       hclk_sync;
  logic       lb_vld;
  logic       take;
  link_byte_t lb;

  ecp_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n)
  );

  ecp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hclk_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(host_clk_i), .q_o(hclk_sync)
  );

  ecp_link_fsm u_link (
    .clk(clk), .rst_n(rst_sync_n), .hclk_sync_i(hclk_sync),
    .pd_i(pd_i), .host_ack_i(host_ack_i), .take_i(take),
    .periph_ack_o(periph_ack_o), .lb_vld_o(lb_vld), .lb_o(lb)
  );

  ecp_rle_expander u_rle (
    .clk(clk), .rst_n(rst_sync_n), .lb_vld_i(lb_vld), .lb_i(lb),
    .take_o(take), .out_vld_o(out_vld_o), .out_rdy_i(out_rdy_i),
    .out_data_o(out_data_o), .chan_o(chan_o)
  );
endmodule

// File: rtl/ecp_fwd_rx_chk.sv
module ecp_fwd_rx_chk
  import ecp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_clk_i,
  input logic             periph_ack_o,
  input logic             out_vld_o,
  input logic             out_rdy_i,
  input logic [PD_W-1:0]  out_data_o,
  input logic [ARG_W-1:0] chan_o
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && !out_rdy_i) |=> (out_vld_o && $stable(out_data_o)));

  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_ack_o) |-> $past(!host_clk_i));

  assert_ack_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_ack_o) |-> $past(host_clk_i));

  assert_out_from_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld_o) |-> $past(periph_ack_o));

  assert_chan_from_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_o) |-> $past(periph_ack_o));
endmodule

bind ecp_fwd_rx ecp_fwd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_clk_i(host_clk_i),
  .periph_ack_o(periph_ack_o), .out_vld_o(out_vld_o),
  .out_rdy_i(out_rdy_i), .out_data_o(out_data_o), .chan_o(chan_o)
);

// File: tb/tb_ecp_fwd_rx.sv
module tb_ecp_fwd_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pd_i = 8'h00;
  logic       host_ack_i = 1'b1;
  logic       host_clk_i = 1'b1;
  logic       periph_ack_o;
  logic       out_vld_o;
  logic       out_rdy_i = 1'b1;
  logic [7:0] out_data_o;
  logic [6:0] chan_o;

  int         n_chk = 0;
  int         n_bad = 0;
  int         rdy_mode = 0;
  int         cyc = 0;
  int         run_m = 0;
  logic [7:0] exp_q[$];

  ecp_fwd_rx dut (
    .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .host_ack_i(host_ack_i),
    .host_clk_i(host_clk_i), .periph_ack_o(periph_ack_o),
    .out_vld_o(out_vld_o), .out_rdy_i(out_rdy_i),
    .out_data_o(out_data_o), .chan_o(chan_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: out_rdy_i <= 1'b1;
      1: out_rdy_i <= ((cyc * 7) % 5) != 0 && (cyc % 11) != 3;
      default: out_rdy_i <= 1'b0;
    endcase
  end

  // R4 R10: every transferred byte compared in order with the model
  always @(negedge clk) begin
    if (rst_n && out_vld_o && out_rdy_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 R4 extra byte", out_data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data_o == e, "R4 stream byte", out_data_o, e);
      end
    end
  end

  task automatic send(input bit cmd, input logic [7:0] v);
    @(negedge clk);
    pd_i = v;
    host_ack_i = ~cmd;
    host_clk_i = 1'b0;
    do @(negedge clk); while (!periph_ack_o);
    host_clk_i = 1'b1;
    do @(negedge clk); while (periph_ack_o);
  endtask

  task automatic send_data(input logic [7:0] v);
    for (int k = 0; k <= run_m; k++) exp_q.push_back(v);
    run_m = 0;
    send(1'b0, v);
  endtask

  task automatic send_run(input int n);
    run_m = n;
    send(1'b1, {1'b0, n[6:0]});
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(exp_q.size() == 0, "R4 drain", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(periph_ack_o == 1'b0, "R1 ack", periph_ack_o, 0);
    chk(out_vld_o == 1'b0, "R1 vld", out_vld_o, 0);
    chk(chan_o == 7'd0, "R1 chan", chan_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(periph_ack_o == 1'b0, "R1 ack idle", periph_ack_o, 0);

    // R1: no pending count, single byte; R2 handshake completes
    send_data(8'hA5);
    drain();

    // R4 R10: sweep every repeat count under throttled ready
    rdy_mode = 1;
    for (int n = 0; n < 128; n++) begin
      send_run(n);
      send_data(8'((n * 37 + 1) & 8'hFF));
    end
    drain();
    // R4: count cleared after use
    send_data(8'h11);
    send_data(8'h22);
    drain();

    // R3: command values never reach the stream; data with bit7 leaves chan alone
    send_data(8'hFF);
    drain();
    chk(chan_o == 7'd0, "R3 data not channel", chan_o, 0);

    // R6: sweep every channel
    rdy_mode = 0;
    for (int c = 0; c < 128; c++) begin
      send(1'b1, 8'(8'h80 | c));
      chk(chan_o == 7'(c), "R6 chan", chan_o, c);
    end
    repeat (5) @(negedge clk);
    chk(out_vld_o == 1'b0, "R3 R6 no output", out_vld_o, 0);
    chk(exp_q.size() == 0, "R3 R6 queue", exp_q.size(), 0);

    // R5: later run replaces; channel keeps pending count
    send_run(3);
    send_run(1);
    send_data(8'h5C);
    drain();
    send_run(2);
    send(1'b1, 8'h85);
    send_data(8'h6D);
    drain();
    chk(chan_o == 7'd5, "R5 chan", chan_o, 5);

    // R8 R9 R7: stall with ready low
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    send_run(20);
    send_data(8'h33);
    send(1'b1, 8'h90);
    chk(chan_o == 7'h10, "R9 cmd during run", chan_o, 7'h10);
    chk(out_vld_o && out_data_o == 8'h33, "R7 R9 held", out_data_o, 8'h33);
    fork
      send_data(8'h44);
      begin
        repeat (40) @(negedge clk);
        chk(periph_ack_o == 1'b1, "R8 stall", periph_ack_o, 1);
        chk(out_data_o == 8'h33, "R7 stable", out_data_o, 8'h33);
        rdy_mode = 0;
      end
    join
    drain();

    // R9: back-to-back runs at full ready
    for (int n = 0; n < 6; n++) begin
      send_run(n);
      send_data(8'(8'hC0 + n));
    end
    drain();
    finish_run();
  end
endmodule